// File: doc/BRIEF.md
# Quad-Direction Knight Attack Generator

This block takes a 64-bit board marking every square that holds a knight and computes the squares those knights attack, split into eight direction lanes. The lanes go out as two 256-bit quad-boards. The north quad-board holds the four moves that raise the rank, each formed by shifting the board toward higher bit indices. The south quad-board holds the four moves that lower the rank, each formed by shifting toward lower bit indices. Each lane has its own shift distance. Each lane also has its own edge mask, which removes targets that would wrap from one side of the board to the other. A 64-bit union of all eight lanes comes out as well.

All four lanes of one direction are formed in the same cycle, as one vector operation. The shift-and-mask logic is combinational and feeds a single registered output stage. Results and the valid flag appear one clock after the input is offered. The block does not check move legality and does not remove squares held by friendly pieces; the consumer does that.

Squares are numbered rank-major: bit index = rank*8 + file, with bit 0 at file a, rank 1, and bit 63 at file h, rank 8.

Top module: `knight_quad_gen`

## Requirements
- R1: While rstN is low, and after its release until the first accepted input, outValid is 0 and northQuad, southQuad and attackUnion are all zero.
- R2: outValid is 1 in exactly the cycles that follow a rising clock edge at which inValid was 1.
- R3: North lane n occupies northQuad bits [64n+63:64n]. Lanes 0 to 3 are the input board shifted left by 10, 17, 15 and 6: east-east-up, up-up-east, up-up-west and west-west-up.
- R4: South lane n occupies southQuad bits [64n+63:64n]. Lanes 0 to 3 are the input board shifted right by 10, 17, 15 and 6: west-west-down, down-down-west, down-down-east and east-east-down.
- R5: Wrap masking. North lanes 0 to 3 clear files {a,b}, {a}, {h} and {g,h} respectively. South lanes 0 to 3 clear files {g,h}, {h}, {a} and {a,b} respectively. File a is file index 0 and file h is index 7.
- R6: Bits shifted above bit 63 or below bit 0 are dropped. A knight on rank 8 produces nothing in the north lanes, and a knight on rank 1 produces nothing in the south lanes.
- R7: attackUnion equals the bitwise OR of all eight lanes of the same result.
- R8: When inValid is 0 at a clock edge, northQuad, southQuad and attackUnion keep their previous values.
- R9: An empty input board yields all-zero lanes and an all-zero union.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low reset, applied synchronously |
| inValid | input | 1 | The board on knightBoard is to be processed this cycle |
| knightBoard | input | 64 | Knight occupancy, bit = rank*8 + file |
| outValid | output | 1 | A fresh result is on the outputs |
| northQuad | output | 256 | Four rank-raising attack lanes, lane n at bits [64n+63:64n] |
| southQuad | output | 256 | Four rank-lowering attack lanes, lane n at bits [64n+63:64n] |
| attackUnion | output | 64 | OR of all eight lanes |

## Verification
The assertions assume that inValid and knightBoard are stable and free of X at each rising edge. Several of them relate a result to the board captured one edge earlier, so they also assume reset is held for at least one edge before the first valid input. The bench meets both conditions. It changes inputs only on falling edges, keeps inValid low for the whole reset, and draws every board from fixed corner patterns or from $urandom words. Those patterns include single knights on each of the 64 squares, full edge files and ranks, the full board and the empty board, sent back to back and with idle gaps between them.

// File: rtl/kq_pkg.sv
package kq_pkg;

  localparam int FILES = 8;
  localparam int RANKS = 8;
  localparam int SQUARES = FILES * RANKS;
  localparam int LANES = 4;
  localparam int QUAD_W = SQUARES * LANES;

  typedef logic [SQUARES-1:0] board_t;
  typedef logic [QUAD_W-1:0] quad_t;

  // control to datapath strobes
  typedef struct packed {
    logic load;
  } kq_strobe_t;

  // rank step of north lane n (south lane n uses the negation)
  function automatic int laneRankStep(input int lane);
    case (lane)
      0: laneRankStep = 1;
      1: laneRankStep = 2;
      2: laneRankStep = 2;
      default: laneRankStep = 1;
    endcase
  endfunction

  // file step of north lane n (south lane n uses the negation)
  function automatic int laneFileStep(input int lane);
    case (lane)
      0: laneFileStep = 2;
      1: laneFileStep = 1;
      2: laneFileStep = -1;
      default: laneFileStep = -2;
    endcase
  endfunction

  // Mask of squares a move with file step fileStep can legally land on.
  // A positive step cannot land in the lowest fileStep files, a negative
  // step cannot land in the highest -fileStep files.
  function automatic board_t edgeMask(input int fileStep);
    board_t m;
    for (int sq = 0; sq < SQUARES; sq++) begin
      int f;
      f = sq % FILES;
      if (fileStep >= 0) m[sq] = (f >= fileStep);
      else m[sq] = (f < FILES + fileStep);
    end
    return m;
  endfunction

endpackage

// File: rtl/kq_ctrl.sv
module kq_ctrl
  import kq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output kq_strobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe = '0;
    strobe.load = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/kq_datapath.sv
module kq_datapath
  import kq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  kq_strobe_t strobe,
  input  board_t     knightBoard,
  output quad_t      northQuad,
  output quad_t      southQuad,
  output board_t     attackUnion
);

  board_t northLane [LANES];
  board_t southLane [LANES];
  quad_t  northNext;
  quad_t  southNext;
  board_t unionNext;

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    localparam int RSTEP = laneRankStep(lane);
    localparam int FSTEP = laneFileStep(lane);
    localparam int SHIFT = RSTEP * FILES + FSTEP;
    localparam board_t NMASK = edgeMask(FSTEP);
    localparam board_t SMASK = edgeMask(-FSTEP);

    assign northLane[lane] = (knightBoard << SHIFT) & NMASK;
    assign southLane[lane] = (knightBoard >> SHIFT) & SMASK;
    assign northNext[lane*SQUARES +: SQUARES] = northLane[lane];
    assign southNext[lane*SQUARES +: SQUARES] = southLane[lane];
  end

  always_comb begin
    unionNext = '0;
    for (int lane = 0; lane < LANES; lane++) begin
      unionNext = unionNext | northLane[lane] | southLane[lane];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      northQuad   <= '0;
      southQuad   <= '0;
      attackUnion <= '0;
    end else if (strobe.load) begin
      northQuad   <= northNext;
      southQuad   <= southNext;
      attackUnion <= unionNext;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(northQuad) && $stable(southQuad) && $stable(attackUnion));

  // R9
  empty_board_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && knightBoard == '0) |=>
      (northQuad == '0 && southQuad == '0 && attackUnion == '0));

  // R7
  union_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ($countones(attackUnion) <= 8 * $countones($past(knightBoard))));

  // R5
  corner_a1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && knightBoard == board_t'(1)) |=>
      (attackUnion == board_t'(64'h0000_0000_0002_0400)));

endmodule

// File: rtl/knight_quad_gen.sv
module knight_quad_gen
  import kq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [63:0]  knightBoard,
  output logic         outValid,
  output logic [255:0] northQuad,
  output logic [255:0] southQuad,
  output logic [63:0]  attackUnion
);

  kq_strobe_t strobe;

  kq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  kq_datapath uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .knightBoard (knightBoard),
    .northQuad   (northQuad),
    .southQuad   (southQuad),
    .attackUnion (attackUnion)
  );

endmodule

// File: tb/tb_knight_quad_gen.sv
module tb_knight_quad_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [63:0]  knightBoard = '0;
  logic         outValid;
  logic [255:0] northQuad;
  logic [255:0] southQuad;
  logic [63:0]  attackUnion;

  knight_quad_gen dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .knightBoard(knightBoard),
    .outValid(outValid), .northQuad(northQuad), .southQuad(southQuad),
    .attackUnion(attackUnion)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [255:0] n;
    logic [255:0] s;
    logic [63:0]  u;
  } exp_t;

  exp_t expQ[$];
  exp_t lastExp = '0;
  int   checks = 0;
  int   failures = 0;
  logic running = 1'b0;
  logic sawValid = 1'b0;
  logic done = 1'b0;

  // Per-square reference: rank and file steps per lane (north lanes; south negated)
  function automatic exp_t model(input logic [63:0] k);
    int rs[4] = '{1, 2, 2, 1};
    int fs[4] = '{2, 1, -1, -2};
    exp_t e;
    e = '0;
    for (int sq = 0; sq < 64; sq++) begin
      if (k[sq]) begin
        for (int ln = 0; ln < 4; ln++) begin
          int r, f, nr, nf;
          r = sq / 8; f = sq % 8;
          nr = r + rs[ln]; nf = f + fs[ln];
          if (nr >= 0 && nr < 8 && nf >= 0 && nf < 8) begin
            e.n[ln*64 + nr*8 + nf] = 1'b1;
            e.u[nr*8 + nf] = 1'b1;
          end
          nr = r - rs[ln]; nf = f - fs[ln];
          if (nr >= 0 && nr < 8 && nf >= 0 && nf < 8) begin
            e.s[ln*64 + nr*8 + nf] = 1'b1;
            e.u[nr*8 + nf] = 1'b1;
          end
        end
      end
    end
    return e;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input exp_t e, input string req);
    chk(northQuad == e.n, {req, " R3 R5 R6"}, "northQuad", northQuad, e.n);
    chk(southQuad == e.s, {req, " R4 R5 R6"}, "southQuad", southQuad, e.s);
    chk(attackUnion == e.u, {req, " R7"}, "attackUnion", {192'b0, attackUnion}, {192'b0, e.u});
  endtask

  task automatic drive(input logic [63:0] k);
    @(negedge clk);
    inValid = 1'b1;
    knightBoard = k;
    expQ.push_back(model(k));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      knightBoard = $urandom();
    end
  endtask

  always @(posedge clk) sawValid <= inValid & rstN;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      chk(outValid == sawValid, "R2", "outValid", {255'b0, outValid}, {255'b0, sawValid});
      if (outValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected result", '0, '0);
        end else begin
          lastExp = expQ.pop_front();
          compareAll(lastExp, "R3 R4");
        end
      end else begin
        compareAll(lastExp, "R8 hold");
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state while reset held
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid in reset", {255'b0, outValid}, '0);
    chk(northQuad == '0, "R1", "northQuad in reset", northQuad, '0);
    chk(southQuad == '0, "R1", "southQuad in reset", southQuad, '0);
    chk(attackUnion == '0, "R1", "attackUnion in reset", {192'b0, attackUnion}, '0);
    rstN = 1'b1;
    running = 1'b1;
    idle(2); // R1: still zero after release (monitor hold check vs zero)

    // corners and edges: R5 wrap masking, R6 off-board discard
    drive(64'h1);                   // a1
    drive(64'h8000_0000_0000_0000); // h8
    drive(64'h80);                  // h1
    drive(64'h0100_0000_0000_0000); // a8
    idle(1);
    drive(64'h0101_0101_0101_0101); // file a, R5
    drive(64'h8080_8080_8080_8080); // file h, R5
    drive(64'h0202_0202_0202_0202); // file b
    drive(64'h4040_4040_4040_4040); // file g
    drive(64'hFF00_0000_0000_0000); // rank 8, R6
    drive(64'h0000_0000_0000_00FF); // rank 1, R6
    drive(64'hFFFF_FFFF_FFFF_FFFF); // full board
    drive(64'h0);                   // R9 empty board
    idle(3);                        // R8 hold over idle cycles

    // every single square, back to back
    for (int sq = 0; sq < 64; sq++) drive(64'h1 << sq);
    idle(2);

    // random boards with gaps
    for (int i = 0; i < 60; i++) begin
      drive({$urandom(), $urandom()});
      if (i % 3 == 0) idle(1 + (i % 4));
    end
    drive(64'h0); // R9
    idle(4);

    chk(expQ.size() == 0, "R2", "pending results", {224'b0, 32'(expQ.size())}, '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule